// File: doc/BRIEF.md
# Host Memory Window Port

This block gives an external host a window into the local memory of a slave graphics processor. The host first loads a 32-bit address, counted in bits, as two 16-bit halves. It then moves 16-bit words through a data register. Each data access becomes one word transaction on the local memory side, at the current address. Two control bits make the address step forward by one word (16 bit positions). Writes step after the access and reads step before it, so the host can stream through consecutive words without reloading the address.

The same control register holds two processor controls. One bit halts the slave processor for as long as it is set. Another bit makes every control write that carries it emit a one-cycle non-maskable interrupt request.

The host side is a command stream plus a response stream, each with a valid/ready handshake. The port takes a command only while it is idle. Once a data access has been taken, the port is busy until the memory acknowledges it. A read stays busy until its response has been accepted. A response is held steady while `rsp_ready` is low. The memory side is a plain request/acknowledge pair, and the request is held steady until the acknowledge arrives.

Top module: `hostwin_port`

## Requirements
- R1: After reset, both address halves and the control register read back as zero, `halt` and `nmi` are low, `mem_req` and `rsp_valid` are low, and `cmd_ready` is high.
- R2: Register select encoding is 0 = address low half, 1 = address high half, 2 = data, 3 = control. A write to select 1 stores the value as given. A write to select 0 stores it with bits 3:0 cleared. Reads of selects 0, 1 and 3 return the stored value as a response.
- R3: A data write issues one memory request with `mem_we` high, `mem_wdata` equal to the written word, and `mem_addr` equal to the 32-bit bit address {high, low} shifted right by 3. All of these are held until `mem_ack`.
- R4: When control bit 11 is set, the address rises by 16 after a data write has been acknowledged. When bit 11 is clear, the address is unchanged.
- R5: When control bit 12 is set, a data read first raises the address by 16 and then reads at the new address. When bit 12 is clear, the read uses the current address and leaves it unchanged.
- R6: An address step carries from the low half into the high half. Both halves are updated, and the sum wraps modulo 2^32.
- R7: A read response is presented with `rsp_valid` and held stable until `rsp_ready`. `cmd_ready` stays low from the acceptance of a data access until that access completes (memory acknowledge for a write, response accepted for a read), and while any response is pending.
- R8: `halt` follows control bit 15 and changes only on a control write.
- R9: Every control write with bit 8 set produces exactly one `nmi` pulse of one cycle, in the cycle after the write is accepted. No other command produces a pulse.
- R10: Control bit 12 has no effect on data writes, and control bit 11 has no effect on data reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Port can take a command this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_sel | input | 2 | Register select (see R2) |
| cmd_wdata | input | 16 | Write value |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 16 | Read value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 29 | Memory byte address |
| mem_wdata | output | 16 | Memory write word |
| mem_ack | input | 1 | Memory completes the access |
| mem_rdata | input | 16 | Memory read word |
| halt | output | 1 | Slave processor halt |
| nmi | output | 1 | Non-maskable interrupt request pulse |

## Verification
The bench goes after the order of the address step relative to the access. A design that pre-steps on writes or post-steps on reads would write words one slot off, and the read-back of the data would then return the wrong value. It sets the low half to 0xFFF0 and steps to check the carry, with the high half both mid-range and at 0xFFFF. A design that drops the carry, or wraps the low half alone, would read back the wrong halves. It also holds the memory acknowledge and the response ready off for several cycles, where a design that took new commands or let request or response fields drift would be caught. Finally, it counts interrupt pulses across repeated control writes, to catch designs that stretch the pulse or keep it level.

// File: rtl/hostwin_pkg.sv
package hostwin_pkg;

  // Register select codes seen on cmd_sel
  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_CTRL    = 2'd3
  } hw_sel_e;

  // Control register bit positions
  localparam int unsigned CTL_HALT_BIT   = 15;
  localparam int unsigned CTL_RDPRE_BIT  = 12;
  localparam int unsigned CTL_WRPOST_BIT = 11;
  localparam int unsigned CTL_NMI_BIT    = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_RSP  = 2'd2
  } hw_state_e;

endpackage

// File: rtl/hostwin_addr.sv
// Bit-granular address register pair with word stepping and carry.
module hostwin_addr #(
  parameter int unsigned W         = 16,
  parameter int unsigned STEP_BITS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_lo,
  input  logic         ld_hi,
  input  logic [W-1:0] ld_data,
  input  logic         bump,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q
);
  localparam int unsigned FULL_W  = 2 * W;
  localparam logic [W-1:0] LO_MASK = ~W'(STEP_BITS - 1);

  logic [FULL_W-1:0] stepped;
  assign stepped = {hi_q, lo_q} + FULL_W'(STEP_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (bump) begin
      {hi_q, lo_q} <= stepped;
    end else begin
      if (ld_lo) lo_q <= ld_data & LO_MASK;
      if (ld_hi) hi_q <= ld_data;
    end
  end
endmodule

// File: rtl/hostwin_ctrl.sv
// Control register: halt level and interrupt request pulse.
module hostwin_ctrl #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] ctrl_q,
  output logic         halt,
  output logic         nmi
);
  import hostwin_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      nmi    <= 1'b0;
    end else begin
      if (ld) ctrl_q <= ld_data;
      nmi <= ld && ld_data[CTL_NMI_BIT];
    end
  end

  assign halt = ctrl_q[CTL_HALT_BIT];
endmodule

// File: rtl/hostwin_seq.sv
// Command sequencer: accepts host commands, runs memory accesses,
// presents responses.
module hostwin_seq #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic         cmd_write,
  input  logic [1:0]   cmd_sel,
  input  logic [W-1:0] cmd_wdata,
  input  logic [W-1:0] ctrl_q,
  input  logic [W-1:0] lo_q,
  input  logic [W-1:0] hi_q,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_ack,
  input  logic [W-1:0] mem_rdata,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data,
  output logic         ld_lo,
  output logic         ld_hi,
  output logic         ld_ctl,
  output logic         bump
);
  import hostwin_pkg::*;

  hw_state_e    state;
  logic         fire;
  logic         is_data;
  logic [W-1:0] reg_view;

  assign cmd_ready = (state == ST_IDLE);
  assign fire      = cmd_valid && cmd_ready;
  assign is_data   = (cmd_sel == SEL_DATA);

  assign ld_lo  = fire && cmd_write && (cmd_sel == SEL_ADDR_LO);
  assign ld_hi  = fire && cmd_write && (cmd_sel == SEL_ADDR_HI);
  assign ld_ctl = fire && cmd_write && (cmd_sel == SEL_CTRL);

  // Pre-step on an accepted data read, post-step on an acknowledged write.
  assign bump = (fire && !cmd_write && is_data && ctrl_q[CTL_RDPRE_BIT]) ||
                ((state == ST_MEM) && mem_ack && mem_we && ctrl_q[CTL_WRPOST_BIT]);

  always_comb begin
    unique case (cmd_sel)
      SEL_ADDR_LO: reg_view = lo_q;
      SEL_ADDR_HI: reg_view = hi_q;
      SEL_CTRL:    reg_view = ctrl_q;
      default:     reg_view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      rsp_data  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (fire) begin
            if (is_data) begin
              state     <= ST_MEM;
              mem_we    <= cmd_write;
              mem_wdata <= cmd_wdata;
            end else if (!cmd_write) begin
              rsp_data <= reg_view;
              state    <= ST_RSP;
            end
          end
        end
        ST_MEM: begin
          if (mem_ack) begin
            if (mem_we) begin
              state <= ST_IDLE;
            end else begin
              rsp_data <= mem_rdata;
              state    <= ST_RSP;
            end
          end
        end
        ST_RSP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == ST_MEM);
  assign rsp_valid = (state == ST_RSP);
endmodule

// File: rtl/hostwin_port.sv
// Host memory window port: top level.
module hostwin_port #(
  parameter int unsigned W          = 16,
  parameter int unsigned STEP_BITS  = 16,
  parameter int unsigned BYTE_SHIFT = 3,
  localparam int unsigned FULL_W    = 2 * W,
  localparam int unsigned MEM_AW    = FULL_W - BYTE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [1:0]        cmd_sel,
  input  logic [W-1:0]      cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [W-1:0]      rsp_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [W-1:0]      mem_wdata,
  input  logic              mem_ack,
  input  logic [W-1:0]      mem_rdata,
  output logic              halt,
  output logic              nmi
);
  logic [W-1:0] lo_q, hi_q, ctrl_q;
  logic         ld_lo, ld_hi, ld_ctl, bump;

  hostwin_addr #(.W(W), .STEP_BITS(STEP_BITS)) addr_i (
    .clk(clk), .rst_n(rst_n), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .ld_data(cmd_wdata), .bump(bump), .lo_q(lo_q), .hi_q(hi_q)
  );

  hostwin_ctrl #(.W(W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ld(ld_ctl), .ld_data(cmd_wdata),
    .ctrl_q(ctrl_q), .halt(halt), .nmi(nmi)
  );

  hostwin_seq #(.W(W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata),
    .ctrl_q(ctrl_q), .lo_q(lo_q), .hi_q(hi_q),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_ctl(ld_ctl), .bump(bump)
  );

  assign mem_addr = MEM_AW'({hi_q, lo_q} >> BYTE_SHIFT);
endmodule

// File: rtl/hostwin_chk.sv
// Protocol and behaviour checks, bound into hostwin_port.
module hostwin_chk #(
  parameter int unsigned W          = 16,
  parameter int unsigned STEP_BITS  = 16,
  parameter int unsigned BYTE_SHIFT = 3,
  localparam int unsigned MEM_AW    = 2 * W - BYTE_SHIFT,
  localparam int unsigned ALIGN     = $clog2(STEP_BITS) - BYTE_SHIFT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [1:0]        cmd_sel,
  input logic              ctl_nmi_req,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [W-1:0]      rsp_data,
  input logic              mem_req,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [W-1:0]      mem_wdata,
  input logic              mem_ack,
  input logic              halt,
  input logic              nmi
);
  import hostwin_pkg::*;

  localparam logic [MEM_AW-1:0] ALIGN_MASK = MEM_AW'((1 << ALIGN) - 1);

  logic ctl_fire;
  assign ctl_fire = cmd_valid && cmd_ready && cmd_write && (cmd_sel == SEL_CTRL);

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata));

  a_r2_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr & ALIGN_MASK) == '0);

  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || rsp_valid) |-> !cmd_ready);

  a_r8_halt_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(halt) |-> $past(ctl_fire));

  a_r9_nmi_source: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> $past(ctl_fire && ctl_nmi_req));

  a_r9_nmi_emitted: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_fire && ctl_nmi_req |=> nmi);
endmodule

bind hostwin_port hostwin_chk #(
  .W(W), .STEP_BITS(STEP_BITS), .BYTE_SHIFT(BYTE_SHIFT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_write(cmd_write), .cmd_sel(cmd_sel),
  .ctl_nmi_req(cmd_wdata[hostwin_pkg::CTL_NMI_BIT]),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .halt(halt), .nmi(nmi)
);

// File: tb/hostwin_port_tb.sv
module hostwin_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [1:0]  cmd_sel = 2'd0;
  logic [15:0] cmd_wdata = 16'h0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_data;
  logic        mem_req;
  logic        mem_we;
  logic [28:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = 16'h0;
  logic        halt;
  logic        nmi;

  int n_tests = 0;
  int n_fail  = 0;
  int nmi_cnt = 0;
  int mem_lat = 0;
  int wait_cnt = 0;
  logic [15:0] mem [64];

  always #4 clk = ~clk;

  hostwin_port dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .halt(halt), .nmi(nmi)
  );

  // Memory model: word slot chosen by byte address bits 6:1, acknowledged
  // after mem_lat idle cycles.
  always @(negedge clk) begin
    if (nmi) nmi_cnt = nmi_cnt + 1;
    if (mem_req) begin
      if (wait_cnt >= mem_lat) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[6:1]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[6:1]];
        wait_cnt = 0;
      end else begin
        mem_ack = 1'b0;
        wait_cnt = wait_cnt + 1;
      end
    end else begin
      mem_ack = 1'b0;
      wait_cnt = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Present one command; returns at the negedge after it was accepted.
  task automatic send(input logic wr, input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_sel = sel; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Read a register; optionally hold rsp_ready low for 'hold' cycles.
  task automatic rd(input logic [1:0] sel, output logic [15:0] data, input int hold);
    logic [15:0] first;
    send(1'b0, sel, 16'h0);
    while (!rsp_valid) @(negedge clk);
    first = rsp_data;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check("R7 response held", {15'd0, rsp_valid, rsp_data}, {15'd0, 1'b1, first});
    end
    rsp_ready = 1'b1;
    data = rsp_data;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  // {requirement number, write, select, data (write value or expected read)}
  localparam int NV = 33;
  localparam logic [22:0] VEC [NV] = '{
    {4'd2,  1'b1, 2'd3, 16'h0000},  // R2 control clear
    {4'd2,  1'b1, 2'd0, 16'h123F},  // R2 low half, bits 3:0 dropped
    {4'd2,  1'b1, 2'd1, 16'h0000},
    {4'd2,  1'b0, 2'd0, 16'h1230},
    {4'd2,  1'b0, 2'd1, 16'h0000},
    {4'd3,  1'b1, 2'd2, 16'hBEEF},  // R3 plain write
    {4'd4,  1'b0, 2'd0, 16'h1230},  // R4 no step when bit 11 clear
    {4'd5,  1'b0, 2'd2, 16'hBEEF},  // R5 read without pre-step
    {4'd5,  1'b0, 2'd0, 16'h1230},
    {4'd4,  1'b1, 2'd3, 16'h0800},  // R4 post-step on
    {4'd4,  1'b1, 2'd2, 16'h1111},
    {4'd4,  1'b1, 2'd2, 16'h2222},
    {4'd4,  1'b0, 2'd0, 16'h1250},
    {4'd5,  1'b1, 2'd3, 16'h1000},  // R5 pre-step on
    {4'd5,  1'b1, 2'd0, 16'h1220},
    {4'd5,  1'b0, 2'd2, 16'h1111},
    {4'd5,  1'b0, 2'd2, 16'h2222},
    {4'd5,  1'b0, 2'd0, 16'h1240},
    {4'd10, 1'b1, 2'd2, 16'h3333},  // R10 bit 12 ignored by writes
    {4'd10, 1'b0, 2'd0, 16'h1240},
    {4'd10, 1'b1, 2'd3, 16'h0800},  // R10 bit 11 ignored by reads
    {4'd10, 1'b0, 2'd2, 16'h3333},
    {4'd10, 1'b0, 2'd0, 16'h1240},
    {4'd6,  1'b1, 2'd0, 16'hFFF0},  // R6 carry on post-step
    {4'd6,  1'b1, 2'd1, 16'h0007},
    {4'd6,  1'b1, 2'd2, 16'h4444},
    {4'd6,  1'b0, 2'd0, 16'h0000},
    {4'd6,  1'b0, 2'd1, 16'h0008},
    {4'd6,  1'b1, 2'd3, 16'h1000},  // R6 carry on pre-step
    {4'd6,  1'b1, 2'd0, 16'hFFE0},
    {4'd6,  1'b1, 2'd1, 16'h0007},
    {4'd6,  1'b0, 2'd2, 16'h4444},
    {4'd2,  1'b0, 2'd3, 16'h1000}   // R2 control read-back
  };

  initial begin
    logic [15:0] v;
    string tag;
    for (int i = 0; i < 64; i++) mem[i] = 16'h5A00 ^ 16'(i);

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cmd_ready", {31'd0, cmd_ready}, 32'd1);
    check("R1 idle outputs", {28'd0, mem_req, rsp_valid, halt, nmi}, 32'd0);
    rst_n = 1'b1;
    rd(2'd0, v, 0); check("R1 low half", {16'd0, v}, 32'd0);
    rd(2'd1, v, 0); check("R1 high half", {16'd0, v}, 32'd0);
    rd(2'd3, v, 0); check("R1 control", {16'd0, v}, 32'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      tag = $sformatf("R%0d vector %0d", VEC[i][22:19], i);
      mem_lat = i % 3;
      if (VEC[i][18]) send(1'b1, VEC[i][17:16], VEC[i][15:0]);
      else begin
        rd(VEC[i][17:16], v, 0);
        check(tag, {16'd0, v}, {16'd0, VEC[i][15:0]});
      end
    end

    // R3 / R7: request fields and busy window under a slow memory
    send(1'b1, 2'd3, 16'h0000);
    send(1'b1, 2'd0, 16'h0100);
    send(1'b1, 2'd1, 16'h0002);
    mem_lat = 3;
    send(1'b1, 2'd2, 16'hCAFE);
    check("R3 request", {2'd0, mem_req, mem_we, mem_addr}, {2'd0, 1'b1, 1'b1, 29'h4020});
    check("R3 wdata", {16'd0, mem_wdata}, {16'd0, 16'hCAFE});
    check("R7 busy during access", {31'd0, cmd_ready}, 32'd0);
    @(negedge clk); @(negedge clk);
    check("R3 held", {2'd0, mem_req, mem_we, mem_addr}, {2'd0, 1'b1, 1'b1, 29'h4020});
    // R7 response back-pressure
    rd(2'd2, v, 3);
    check("R7 read data", {16'd0, v}, {16'd0, 16'hCAFE});

    // R6 wrap at the top of the address space
    mem_lat = 0;
    send(1'b1, 2'd3, 16'h0800);
    send(1'b1, 2'd0, 16'hFFF0);
    send(1'b1, 2'd1, 16'hFFFF);
    send(1'b1, 2'd2, 16'h7777);
    rd(2'd0, v, 0); check("R6 wrap low", {16'd0, v}, 32'd0);
    rd(2'd1, v, 0); check("R6 wrap high", {16'd0, v}, 32'd0);

    // R8 halt level
    send(1'b1, 2'd3, 16'h8000);
    check("R8 halt set", {31'd0, halt}, 32'd1);
    rd(2'd0, v, 0);
    check("R8 halt kept over read", {31'd0, halt}, 32'd1);
    send(1'b1, 2'd3, 16'h0000);
    check("R8 halt clear", {31'd0, halt}, 32'd0);

    // R9 interrupt pulses
    nmi_cnt = 0;
    send(1'b1, 2'd3, 16'h0100);
    repeat (3) @(negedge clk);
    check("R9 one pulse", nmi_cnt, 32'd1);
    send(1'b1, 2'd3, 16'h0100);
    send(1'b1, 2'd3, 16'h0100);
    repeat (3) @(negedge clk);
    check("R9 pulse per write", nmi_cnt, 32'd3);
    send(1'b1, 2'd3, 16'h0000);
    rd(2'd3, v, 0);
    repeat (3) @(negedge clk);
    check("R9 no pulse without bit 8", nmi_cnt, 32'd3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog (R7 progress): got hung expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule